// File: doc/BRIEF.md
# Interval Timer Host Register Unit

This unit is the processor-facing register logic of a three-channel interval timer. A 2-bit register select picks one of the three channel data ports or the control port. Control writes carry the channel, the byte access pattern and the operating mode. Data writes assemble a new count from one or two bytes and hand it to the channel's counting element. Data reads return bytes of the live count, of a frozen count snapshot, or of a status byte.

The counting elements are outside this unit. Each one supplies its live 16-bit count, its output level and a flag saying that a written count is still waiting to be loaded. In return it receives a decoded mode, a strobe when its control word is rewritten, and a load strobe with the assembled count.

A latch command freezes one channel's count, so that a two-byte read returns one coherent value. A multi-channel read-back command can freeze the count, the status, or both, on any set of channels at once. Reads and writes on the same channel keep separate byte toggles, so the two byte sequences may be interleaved.

Top module: `timer_host_regs`

## Requirements
- R1: Register select 3 is the control port and selects 0..2 are the channel data ports. In a control word, bits 7:6 give the channel (0..2; 3 means read-back) and bits 5:4 give the access pattern: 00 count latch, 01 low byte only, 10 high byte only, 11 low then high. A control word with a nonzero access field pulses that channel's `cw_wr_o` bit during the write cycle, and only that bit.
- R2: `mode_o` carries control word bits 3:1. When bit 2 is 1, bit 3 is ignored, so the raw codes 6 and 7 appear as 2 and 3.
- R3: A data write with the low-only pattern loads `{8'h00, byte}`, and one with the high-only pattern loads `{byte, 8'h00}`. `load_o` pulses for exactly one cycle, in the cycle after the write edge, with `load_val_o` valid at the same time.
- R4: With the low-then-high pattern, the first data write is held and produces no load. The second write pulses `load_o` once, with the value `{second, first}`.
- R5: With no snapshot pending, a read returns a byte of the live count: the low byte for low-only, the high byte for high-only, and the low byte then the high byte alternately for low-then-high.
- R6: A count latch command freezes the live count. Reads then return the frozen value until the access pattern's byte sequence is complete; after that, reads return the live count again.
- R7: A latched count or a latched status persists until it is read. Further latch or read-back requests for that item are ignored while it is unread.
- R8: A read-back control word has bits 7:6 = 11. Bit 5 = 0 latches the count and bit 4 = 0 latches the status. Bits 1, 2 and 3 select channels 0, 1 and 2, and any combination of them may be set.
- R9: The status byte is {output level, null-count flag, bits 5:0 of that channel's last control word}, captured when the read-back command is written.
- R10: When both status and count are latched, the first read returns the status and the following reads return the count bytes.
- R11: Read and write byte toggles are separate: on one channel, interleaved reads and writes in the low-then-high pattern each complete their own sequence correctly.
- R12: Writing a channel's control word resets both of its byte toggles, so the next read and the next write both start with the low byte.
- R13: After reset every channel holds control field 0x30 (low then high, mode 0), both toggles are clear, no snapshot is pending and `load_o` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sel_i | input | 2 | Register select: 0..2 channel data, 3 control |
| wr_en_i | input | 1 | Write strobe for the selected register |
| rd_en_i | input | 1 | Read strobe; advances the read sequence at the clock edge |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data of the selected register (0 for the control port) |
| cnt_live_i | input | NUM_CH*16 | Live count of each counting element |
| out_lvl_i | input | NUM_CH | Output level of each counting element |
| null_cnt_i | input | NUM_CH | Count-not-yet-loaded flag of each counting element |
| mode_o | output | NUM_CH*3 | Decoded operating mode per channel |
| cw_wr_o | output | NUM_CH | Control word written strobe per channel |
| load_o | output | NUM_CH | New count ready strobe per channel |
| load_val_o | output | NUM_CH*16 | Assembled count per channel |

## Verification
`cw_wr_o` is combinational and is due in the same cycle as the control write. `load_o` and `load_val_o` come from registers and are due one clock after the write edge, then drop one clock later. `rdata_o` is a combinational view of registered state: the byte for a read is present while `rd_en_i` is high, and the sequence advances at that edge. The bench drives inputs on the falling edge and samples 1 ns after it. It takes the read byte before the rising edge that consumes it, and checks loads at the next falling edge and at the one after.

// File: rtl/timer_host_pkg.sv
package timer_host_pkg;
    localparam int BYTE_W = 8;
    localparam int CNT_W  = 2 * BYTE_W;
    localparam int MODE_W = 3;
    localparam int CWF_W  = 6;

    typedef enum logic [1:0] {
        ACC_LATCH = 2'b00,
        ACC_LO    = 2'b01,
        ACC_HI    = 2'b10,
        ACC_LH    = 2'b11
    } acc_t;

    localparam logic [CWF_W-1:0] CWF_RESET = 6'h30;
    localparam logic [1:0]       SEL_CTL   = 2'd3;
endpackage

// File: rtl/thr_cw_decode.sv
module thr_cw_decode
    import timer_host_pkg::*;
#(
    parameter int NUM_CH = 3
) (
    input  logic              ctl_wr_i,
    input  logic [BYTE_W-1:0] cw_i,
    output logic [NUM_CH-1:0] cw_wr_o,
    output logic [NUM_CH-1:0] cnt_latch_o,
    output logic [NUM_CH-1:0] st_latch_o
);
    logic [1:0] chan_f;
    logic       is_rb;
    acc_t       acc_f;

    assign chan_f = cw_i[7:6];
    assign acc_f  = acc_t'(cw_i[5:4]);
    assign is_rb  = (chan_f == SEL_CTL);

    for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
        logic hit;
        logic rb_pick;
        assign hit     = ctl_wr_i && !is_rb && (chan_f == 2'(i));
        assign rb_pick = ctl_wr_i && is_rb && cw_i[1 + i];
        assign cw_wr_o[i]     = hit && (acc_f != ACC_LATCH);
        assign cnt_latch_o[i] = (hit && (acc_f == ACC_LATCH)) || (rb_pick && !cw_i[5]);
        assign st_latch_o[i]  = rb_pick && !cw_i[4];
    end
endmodule

// File: rtl/thr_channel.sv
module thr_channel
    import timer_host_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cw_wr_i,
    input  logic [CWF_W-1:0]  cw_i,
    input  logic              cnt_latch_i,
    input  logic              st_latch_i,
    input  logic              data_wr_i,
    input  logic              data_rd_i,
    input  logic [BYTE_W-1:0] wdata_i,
    input  logic [CNT_W-1:0]  live_cnt_i,
    input  logic              live_out_i,
    input  logic              live_null_i,
    output logic [BYTE_W-1:0] rdata_o,
    output logic [MODE_W-1:0] mode_o,
    output logic              load_o,
    output logic [CNT_W-1:0]  load_val_o
);
    typedef struct packed {
        logic [CWF_W-1:0]  cw;
        logic              rd_hi;
        logic              wr_hi;
        logic [BYTE_W-1:0] lo_hold;
        logic              cnt_vld;
        logic [CNT_W-1:0]  cnt_lat;
        logic              st_vld;
        logic [BYTE_W-1:0] st_lat;
        logic              load;
        logic [CNT_W-1:0]  load_val;
    } ch_state_t;

    ch_state_t s_d, s_q;
    acc_t      acc;
    logic      seq_done;
    logic      byte_hi;
    logic [CNT_W-1:0] rd_src;

    assign acc = acc_t'(s_q.cw[5:4]);

    always_comb begin
        s_d      = s_q;
        s_d.load = 1'b0;
        seq_done = 1'b0;

        if (data_wr_i) begin
            case (acc)
                ACC_LO: begin
                    s_d.load_val = {{BYTE_W{1'b0}}, wdata_i};
                    s_d.load     = 1'b1;
                end
                ACC_HI: begin
                    s_d.load_val = {wdata_i, {BYTE_W{1'b0}}};
                    s_d.load     = 1'b1;
                end
                ACC_LH: begin
                    if (!s_q.wr_hi) begin
                        s_d.lo_hold = wdata_i;
                        s_d.wr_hi   = 1'b1;
                    end else begin
                        s_d.load_val = {wdata_i, s_q.lo_hold};
                        s_d.load     = 1'b1;
                        s_d.wr_hi    = 1'b0;
                    end
                end
                default: ;
            endcase
        end

        if (data_rd_i) begin
            if (s_q.st_vld) begin
                s_d.st_vld = 1'b0;
            end else begin
                seq_done = (acc != ACC_LH) || s_q.rd_hi;
                if (acc == ACC_LH) s_d.rd_hi = !s_q.rd_hi;
                if (seq_done)      s_d.cnt_vld = 1'b0;
            end
        end

        if (cnt_latch_i && !s_q.cnt_vld) begin
            s_d.cnt_vld = 1'b1;
            s_d.cnt_lat = live_cnt_i;
        end

        if (st_latch_i && !s_q.st_vld) begin
            s_d.st_vld = 1'b1;
            s_d.st_lat = {live_out_i, live_null_i, s_q.cw};
        end

        if (cw_wr_i) begin
            s_d.cw    = cw_i;
            s_d.rd_hi = 1'b0;
            s_d.wr_hi = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q          <= '0;
            s_q.cw       <= CWF_RESET;
        end else begin
            s_q <= s_d;
        end
    end

    assign rd_src  = s_q.cnt_vld ? s_q.cnt_lat : live_cnt_i;
    assign byte_hi = (acc == ACC_HI) || ((acc == ACC_LH) && s_q.rd_hi);

    always_comb begin
        if (s_q.st_vld)   rdata_o = s_q.st_lat;
        else if (byte_hi) rdata_o = rd_src[CNT_W-1:BYTE_W];
        else              rdata_o = rd_src[BYTE_W-1:0];
    end

    assign mode_o     = s_q.cw[2] ? {1'b0, s_q.cw[2:1]} : s_q.cw[3:1];
    assign load_o     = s_q.load;
    assign load_val_o = s_q.load_val;

    // R7: an unread status snapshot stays put
    p_status_kept_r7: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.st_vld && !data_rd_i |=> s_q.st_vld && $stable(s_q.st_lat));

    // R7: an unread count snapshot stays put
    p_count_kept_r7: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.cnt_vld && !data_rd_i |=> s_q.cnt_vld && $stable(s_q.cnt_lat));

    // R10: reading the status leaves a latched count pending
    p_status_first_r10: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.st_vld && s_q.cnt_vld && data_rd_i |=> s_q.cnt_vld && !s_q.st_vld);

    // R12: control write clears both toggles
    p_cw_clears_toggles_r12: assert property (@(posedge clk) disable iff (!rst_n)
        cw_wr_i |=> !s_q.rd_hi && !s_q.wr_hi);

    // R4: second byte of a pair produces a load built from the held first byte
    p_pair_load_r4: assert property (@(posedge clk) disable iff (!rst_n)
        data_wr_i && (acc == ACC_LH) && s_q.wr_hi
        |=> load_o && (load_val_o[BYTE_W-1:0] == $past(s_q.lo_hold)));

    // R3: a load strobe never lasts two cycles without a new write
    p_load_single_r3: assert property (@(posedge clk) disable iff (!rst_n)
        load_o && !data_wr_i |=> !load_o);
endmodule

// File: rtl/timer_host_regs.sv
module timer_host_regs
    import timer_host_pkg::*;
#(
    parameter int NUM_CH = 3
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [1:0]               sel_i,
    input  logic                     wr_en_i,
    input  logic                     rd_en_i,
    input  logic [7:0]               wdata_i,
    output logic [7:0]               rdata_o,
    input  logic [NUM_CH*CNT_W-1:0]  cnt_live_i,
    input  logic [NUM_CH-1:0]        out_lvl_i,
    input  logic [NUM_CH-1:0]        null_cnt_i,
    output logic [NUM_CH*MODE_W-1:0] mode_o,
    output logic [NUM_CH-1:0]        cw_wr_o,
    output logic [NUM_CH-1:0]        load_o,
    output logic [NUM_CH*CNT_W-1:0]  load_val_o
);
    logic [NUM_CH-1:0] cw_wr;
    logic [NUM_CH-1:0] cnt_latch;
    logic [NUM_CH-1:0] st_latch;
    logic [BYTE_W-1:0] ch_rdata [NUM_CH];
    logic              ctl_wr;

    assign ctl_wr = wr_en_i && (sel_i == SEL_CTL);

    thr_cw_decode #(.NUM_CH(NUM_CH)) u_dec (
        .ctl_wr_i    (ctl_wr),
        .cw_i        (wdata_i),
        .cw_wr_o     (cw_wr),
        .cnt_latch_o (cnt_latch),
        .st_latch_o  (st_latch)
    );

    for (genvar i = 0; i < NUM_CH; i++) begin : g_chan
        logic picked;
        assign picked = (sel_i == 2'(i));

        thr_channel u_ch (
            .clk         (clk),
            .rst_n       (rst_n),
            .cw_wr_i     (cw_wr[i]),
            .cw_i        (wdata_i[CWF_W-1:0]),
            .cnt_latch_i (cnt_latch[i]),
            .st_latch_i  (st_latch[i]),
            .data_wr_i   (wr_en_i && picked),
            .data_rd_i   (rd_en_i && picked),
            .wdata_i     (wdata_i),
            .live_cnt_i  (cnt_live_i[i*CNT_W +: CNT_W]),
            .live_out_i  (out_lvl_i[i]),
            .live_null_i (null_cnt_i[i]),
            .rdata_o     (ch_rdata[i]),
            .mode_o      (mode_o[i*MODE_W +: MODE_W]),
            .load_o      (load_o[i]),
            .load_val_o  (load_val_o[i*CNT_W +: CNT_W])
        );
    end

    always_comb begin
        rdata_o = '0;
        for (int k = 0; k < NUM_CH; k++) begin
            if (sel_i == 2'(k)) rdata_o = ch_rdata[k];
        end
    end

    assign cw_wr_o = cw_wr;

    // R1: a control word addresses at most one channel
    p_cw_onehot_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(cw_wr));

    // R1: data-port writes never count as control words
    p_data_not_ctl_r1: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en_i && (sel_i != SEL_CTL) |-> (cw_wr == '0));
endmodule

// File: tb/timer_host_regs_bench.sv
`timescale 1ns/1ps
module timer_host_regs_bench;
    localparam int NCH = 3;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  sel = 2'd0;
    logic        wr_en = 1'b0;
    logic        rd_en = 1'b0;
    logic [7:0]  wdata = 8'h00;
    logic [7:0]  rdata;
    logic [NCH*16-1:0] cnt_live = '0;
    logic [NCH-1:0]    out_lvl = '0;
    logic [NCH-1:0]    null_cnt = '0;
    logic [NCH*3-1:0]  mode;
    logic [NCH-1:0]    cw_wr;
    logic [NCH-1:0]    load;
    logic [NCH*16-1:0] load_val;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;
    logic [NCH-1:0] seen_cw_wr;

    always #5 clk = ~clk;

    timer_host_regs #(.NUM_CH(NCH)) u_timer_host_regs (
        .clk(clk), .rst_n(rst_n), .sel_i(sel), .wr_en_i(wr_en), .rd_en_i(rd_en),
        .wdata_i(wdata), .rdata_o(rdata), .cnt_live_i(cnt_live), .out_lvl_i(out_lvl),
        .null_cnt_i(null_cnt), .mode_o(mode), .cw_wr_o(cw_wr), .load_o(load),
        .load_val_o(load_val)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic set_live(input int ch, input logic [15:0] v);
        cnt_live[ch*16 +: 16] = v;
    endtask

    task automatic put(input logic [1:0] s, input logic [7:0] d);
        @(negedge clk);
        sel = s; wdata = d; wr_en = 1'b1;
        #1 seen_cw_wr = cw_wr;
        @(negedge clk);
        wr_en = 1'b0;
        #1;
    endtask

    task automatic get(input logic [1:0] s, output logic [7:0] v);
        @(negedge clk);
        sel = s; rd_en = 1'b1;
        #1 v = rdata;
        @(negedge clk);
        rd_en = 1'b0;
        #1;
    endtask

    task automatic expect_load(input string req, input int ch, input logic [15:0] v);
        check(req, int'(load[ch]), 1);
        check(req, int'(load_val[ch*16 +: 16]), int'(v));
        @(negedge clk); #1;
        check(req, int'(load[ch]), 0);
    endtask

    task automatic t_reset();
        logic [7:0] b;
        check("R13 load", int'(load), 0);
        check("R13 mode", int'(mode), 0);
        set_live(0, 16'hBEEF);
        get(2'd0, b); check("R13 first byte low", int'(b), 8'hEF);
        get(2'd0, b); check("R13 second byte high", int'(b), 8'hBE);
    endtask

    task automatic t_mode();
        put(2'd3, 8'h5E);
        check("R1 cw strobe ch1", int'(seen_cw_wr), 3'b010);
        check("R2 raw 7 -> 3", int'(mode[3 +: 3]), 3);
        put(2'd3, 8'hBA);
        check("R1 cw strobe ch2", int'(seen_cw_wr), 3'b100);
        check("R2 mode 5 kept", int'(mode[6 +: 3]), 5);
        put(2'd3, 8'h3C);
        check("R2 raw 6 -> 2", int'(mode[0 +: 3]), 2);
        put(2'd0, 8'h3C);
        check("R1 data write not control", int'(seen_cw_wr), 0);
    endtask

    task automatic t_write();
        put(2'd1, 8'hA5);
        expect_load("R3 low only", 1, 16'h00A5);
        put(2'd3, 8'h20);
        put(2'd0, 8'h77);
        expect_load("R3 high only", 0, 16'h7700);
        put(2'd2, 8'h34);
        check("R4 no load after first byte", int'(load[2]), 0);
        put(2'd2, 8'h12);
        expect_load("R4 pair", 2, 16'h1234);
    endtask

    task automatic t_live();
        logic [7:0] b;
        set_live(0, 16'hBEEF);
        get(2'd0, b); check("R5 high only", int'(b), 8'hBE);
        put(2'd3, 8'h30);
        get(2'd0, b); check("R5 pair low", int'(b), 8'hEF);
        get(2'd0, b); check("R5 pair high", int'(b), 8'hBE);
        set_live(1, 16'h1357);
        get(2'd1, b); check("R5 low only", int'(b), 8'h57);
        get(2'd1, b); check("R5 low only again", int'(b), 8'h57);
    endtask

    task automatic t_latch();
        logic [7:0] b;
        set_live(0, 16'h1111);
        put(2'd3, 8'h00);
        set_live(0, 16'h2222);
        put(2'd3, 8'h00);
        get(2'd0, b); check("R6 frozen low", int'(b), 8'h11);
        get(2'd0, b); check("R7 second latch ignored", int'(b), 8'h11);
        get(2'd0, b); check("R6 live after sequence", int'(b), 8'h22);
        get(2'd0, b);
    endtask

    task automatic t_readback();
        logic [7:0] b;
        out_lvl = 3'b010; null_cnt = 3'b100;
        put(2'd3, 8'hEC);
        out_lvl = 3'b101; null_cnt = 3'b011;
        put(2'd3, 8'hEC);
        set_live(1, 16'h0042);
        get(2'd1, b); check("R9 status ch1", int'(b), 8'h9E);
        get(2'd2, b); check("R8 R9 status ch2", int'(b), 8'h7A);
        get(2'd1, b); check("R8 count not latched", int'(b), 8'h42);
    endtask

    task automatic t_both();
        logic [7:0] b;
        out_lvl = 3'b000; null_cnt = 3'b000;
        set_live(0, 16'hCAFE);
        put(2'd3, 8'hC2);
        set_live(0, 16'h0000);
        get(2'd0, b); check("R10 status first", int'(b), 8'h30);
        get(2'd0, b); check("R10 count low", int'(b), 8'hFE);
        get(2'd0, b); check("R10 count high", int'(b), 8'hCA);
    endtask

    task automatic t_interleave();
        logic [7:0] b;
        set_live(2, 16'h4321);
        put(2'd2, 8'h55);
        get(2'd2, b); check("R11 read low", int'(b), 8'h21);
        put(2'd2, 8'h66);
        expect_load("R11 write pair", 2, 16'h6655);
        get(2'd2, b); check("R11 read high", int'(b), 8'h43);
    endtask

    task automatic t_cw_reset();
        logic [7:0] b;
        set_live(0, 16'hA1B2);
        get(2'd0, b);
        put(2'd0, 8'h99);
        put(2'd3, 8'h30);
        get(2'd0, b); check("R12 read restarts low", int'(b), 8'hB2);
        put(2'd0, 8'h11);
        check("R12 no load on first byte", int'(load[0]), 0);
        put(2'd0, 8'h22);
        expect_load("R12 write restarts low", 0, 16'h2211);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        t_reset();
        t_mode();
        t_write();
        t_live();
        t_latch();
        t_readback();
        t_both();
        t_interleave();
        t_cw_reset();
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual running expected finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule